// File: doc/BRIEF.md
# Ethernet PHY Management Control Register

This block is the basic-mode configuration word of a 100 Mbps Ethernet PHY. The management engine, which decodes the serial frames, presents a register address with a write strobe and write data, and takes read data back. When the address matches, the block stores the user mode bits: loopback, power-down, isolate, duplex and collision test. A fixed speed bit and the unsupported auto-negotiation fields read as constants. The stored bits drive the datapath control outputs.

Two operations take a long time and are timed by one shared counter whose terminal count is a parameter. A software reset starts when bit 15 is written with 1. The word returns to its defaults and a one-cycle clear pulse goes to the sibling registers. Bit 15 then reads 1, and further writes are refused, until the timeout ends. Leaving power-down starts a power-up recovery. During the recovery a busy flag stays high and the datapaths stay disabled. At the end, an error-clear pulse goes out. An asynchronous hardware reset loads the defaults at once. The isolate default comes from the strapped PHY address.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: After hardware reset the word reads 0x2400 when the strapped PHY address is 0, and 0x2000 for any other address. busy_o and both pulse outputs are low.
- R2: Bit 13 always reads 1. Bits 12, 9 and 6..0 always read 0, whatever value is written.
- R3: Bits 14 (loopback), 11 (power-down), 10 (isolate), 8 (duplex, 1 = full) and 7 (collision test) are stored on an accepted write and read back unchanged.
- R4: An accepted write with bit 15 set loads the defaults and ignores the other written bits. From the cycle after the accepting edge, bit 15 reads 1 for exactly TIMEOUT_CYC cycles and then reads 0.
- R5: While bit 15 reads 1, writes leave the word unchanged.
- R6: srst_pulse_o is high for exactly one cycle, the cycle after the edge that accepts the reset write.
- R7: loopback_o follows bit 14. col_det_en_o is low only when bit 14 is 1 and bit 7 is 0.
- R8: While bit 11 is set, pwrdn_o and isolate_o are high. isolate_o is also high whenever bit 10 is set or a timed sequence runs.
- R9: An accepted write that clears bit 11 while it was set holds busy_o, pwrdn_o and isolate_o high for exactly TIMEOUT_CYC cycles. err_clear_o is then high for one cycle, the first cycle in which busy_o is low again.
- R10: Writes to any address other than CTRL_ADDR are ignored. Reads from any such address return 0.
- R11: A software reset, or a write that sets bit 11 again, ends a running power-up sequence without an err_clear_o pulse. The software reset then runs its own full timeout.
- R12: full_dplx_o follows bit 8 and col_test_o follows bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phy_addr | input | PHYAD_W | Strapped PHY address, selects the isolate default |
| reg_addr | input | ADDR_W | Management register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational on reg_addr) |
| loopback_o | output | 1 | Loopback enable |
| isolate_o | output | 1 | Data interface isolated |
| pwrdn_o | output | 1 | Low-power state held |
| full_dplx_o | output | 1 | Full-duplex select |
| col_test_o | output | 1 | Collision signal test |
| col_det_en_o | output | 1 | Collision detection enable |
| srst_pulse_o | output | 1 | One-cycle clear for sibling registers |
| err_clear_o | output | 1 | One-cycle error clear at end of power-up |
| busy_o | output | 1 | Timed sequence in progress |

## Verification
Stored bits and read data change in the cycle after the accepting edge, because the read path is combinational from the stored state. srst_pulse_o rises one cycle after that edge. busy_o then lasts TIMEOUT_CYC cycles, and err_clear_o follows in the first idle cycle. The bench drives inputs just after the rising edge. It steps a behavioural model on each rising edge and compares every output on the falling edge. The directed checks count falling edges from the accepting write and sample at the exact cycle each result is due.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int unsigned REG_W     = 16;
  localparam int unsigned B_SRST    = 15;
  localparam int unsigned B_LPBK    = 14;
  localparam int unsigned B_SPEED   = 13;
  localparam int unsigned B_PWDN    = 11;
  localparam int unsigned B_ISO     = 10;
  localparam int unsigned B_FDX     = 8;
  localparam int unsigned B_COLT    = 7;

  typedef struct packed {
    logic lpbk;
    logic pwdn;
    logic iso;
    logic fdx;
    logic colt;
  } ctl_fields_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SRST  = 2'd1,
    SEQ_PWRUP = 2'd2
  } seq_state_t;

endpackage

// File: rtl/phy_ctl_fields.sv
module phy_ctl_fields
  import phy_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iso_dflt,
  input  logic        wr_acc,
  input  logic        srst_busy,
  input  logic        w_srst,
  input  ctl_fields_t w_fld,
  output ctl_fields_t fld_q,
  output logic        start_srst,
  output logic        start_pwrup,
  output logic        cancel_pwrup
);

  ctl_fields_t fld_d;
  ctl_fields_t dflt;

  always_comb begin
    dflt      = '0;
    dflt.iso  = iso_dflt;
  end

  always_comb begin
    start_srst   = wr_acc && w_srst;
    start_pwrup  = wr_acc && !w_srst && fld_q.pwdn && !w_fld.pwdn;
    cancel_pwrup = wr_acc && !w_srst && w_fld.pwdn;
  end

  always_comb begin
    fld_d = fld_q;
    if (start_srst) begin
      fld_d = dflt;
    end else if (wr_acc) begin
      fld_d = w_fld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= dflt;
    end else if (wr_acc) begin
      fld_q <= fld_d;
    end
  end

  property p_frozen;
    @(posedge clk) disable iff (!rst_n) srst_busy |=> $stable(fld_q);
  endproperty
  AST_FIELDS_FROZEN: assert property (p_frozen); // R5

endmodule

// File: rtl/phy_ctl_seq.sv
module phy_ctl_seq
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_srst,
  input  logic start_pwrup,
  input  logic cancel_pwrup,
  output logic srst_busy,
  output logic pwrup_busy,
  output logic srst_pulse,
  output logic err_clear
);

  localparam int unsigned CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_d, eclr_d;
  logic             done;

  assign done = (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    eclr_d  = 1'b0;
    if (state_q != SEQ_IDLE) begin
      cnt_d = cnt_q + 1'b1;
      if (done) begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
        eclr_d  = (state_q == SEQ_PWRUP);
      end
    end
    if (start_srst) begin
      state_d = SEQ_SRST;
      cnt_d   = '0;
      pulse_d = 1'b1;
      eclr_d  = 1'b0;
    end else if (cancel_pwrup && state_q == SEQ_PWRUP) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
      eclr_d  = 1'b0;
    end else if (start_pwrup) begin
      state_d = SEQ_PWRUP;
      cnt_d   = '0;
      eclr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_IDLE;
      cnt_q      <= '0;
      srst_pulse <= 1'b0;
      err_clear  <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      srst_pulse <= pulse_d;
      err_clear  <= eclr_d;
    end
  end

  assign srst_busy  = (state_q == SEQ_SRST);
  assign pwrup_busy = (state_q == SEQ_PWRUP);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |=> !srst_pulse); // R6
  AST_ECLR_AFTER_PWRUP: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |-> $past(state_q) == SEQ_PWRUP); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R4

endmodule

// File: rtl/phy_ctl_view.sv
module phy_ctl_view
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_fields_t       fld,
  input  logic              reg_sel,
  input  logic              srst_busy,
  input  logic              pwrup_busy,
  output logic [REG_W-1:0]  rdata,
  output logic              loopback_o,
  output logic              isolate_o,
  output logic              pwrdn_o,
  output logic              full_dplx_o,
  output logic              col_test_o,
  output logic              col_det_en_o
);

  logic [REG_W-1:0] word;

  always_comb begin
    word           = '0;
    word[B_SRST]   = srst_busy;
    word[B_LPBK]   = fld.lpbk;
    word[B_SPEED]  = 1'b1;
    word[B_PWDN]   = fld.pwdn;
    word[B_ISO]    = fld.iso;
    word[B_FDX]    = fld.fdx;
    word[B_COLT]   = fld.colt;
    rdata          = reg_sel ? word : '0;
  end

  always_comb begin
    loopback_o   = fld.lpbk;
    pwrdn_o      = fld.pwdn | pwrup_busy;
    isolate_o    = fld.iso | fld.pwdn | pwrup_busy | srst_busy;
    full_dplx_o  = fld.fdx;
    col_test_o   = fld.colt;
    col_det_en_o = !fld.lpbk | fld.colt;
  end

  AST_PD_ISOLATES: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_o |-> isolate_o); // R8

endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned PHYAD_W     = 5,
  parameter int unsigned CTRL_ADDR   = 0,
  parameter int unsigned TIMEOUT_CYC = 50_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHYAD_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  output logic               loopback_o,
  output logic               isolate_o,
  output logic               pwrdn_o,
  output logic               full_dplx_o,
  output logic               col_test_o,
  output logic               col_det_en_o,
  output logic               srst_pulse_o,
  output logic               err_clear_o,
  output logic               busy_o
);

  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(CTRL_ADDR);

  logic        rs_s1, rst_q_n;
  logic        reg_sel, wr_acc, iso_dflt;
  logic        srst_busy, pwrup_busy;
  logic        start_srst, start_pwrup, cancel_pwrup;
  ctl_fields_t fld_q, w_fld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_s1   <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rs_s1   <= 1'b1;
      rst_q_n <= rs_s1;
    end
  end

  always_comb begin
    reg_sel    = (reg_addr == SEL_ADDR);
    wr_acc     = reg_wr && reg_sel && !srst_busy;
    iso_dflt   = (phy_addr == '0);
    w_fld.lpbk = reg_wdata[B_LPBK];
    w_fld.pwdn = reg_wdata[B_PWDN];
    w_fld.iso  = reg_wdata[B_ISO];
    w_fld.fdx  = reg_wdata[B_FDX];
    w_fld.colt = reg_wdata[B_COLT];
  end

  phy_ctl_fields i_fields (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .iso_dflt     (iso_dflt),
    .wr_acc       (wr_acc),
    .srst_busy    (srst_busy),
    .w_srst       (reg_wdata[B_SRST]),
    .w_fld        (w_fld),
    .fld_q        (fld_q),
    .start_srst   (start_srst),
    .start_pwrup  (start_pwrup),
    .cancel_pwrup (cancel_pwrup)
  );

  phy_ctl_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_seq (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .start_srst   (start_srst),
    .start_pwrup  (start_pwrup),
    .cancel_pwrup (cancel_pwrup),
    .srst_busy    (srst_busy),
    .pwrup_busy   (pwrup_busy),
    .srst_pulse   (srst_pulse_o),
    .err_clear    (err_clear_o)
  );

  phy_ctl_view i_view (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .fld          (fld_q),
    .reg_sel      (reg_sel),
    .srst_busy    (srst_busy),
    .pwrup_busy   (pwrup_busy),
    .rdata        (reg_rdata),
    .loopback_o   (loopback_o),
    .isolate_o    (isolate_o),
    .pwrdn_o      (pwrdn_o),
    .full_dplx_o  (full_dplx_o),
    .col_test_o   (col_test_o),
    .col_det_en_o (col_det_en_o)
  );

  assign busy_o = srst_busy | pwrup_busy;

  AST_PWRUP_BUSY: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($fell(fld_q.pwdn) && !srst_pulse_o) |-> busy_o); // R9

endmodule

// File: tb/test_phy_mgmt_ctrl.sv
`timescale 1ns/1ps
module test_phy_mgmt_ctrl;

  localparam int T = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  phy_addr = 5'd0;
  logic [4:0]  reg_addr = 5'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic loopback_o, isolate_o, pwrdn_o, full_dplx_o, col_test_o, col_det_en_o;
  logic srst_pulse_o, err_clear_o, busy_o;

  int errors = 0;
  int checks = 0;
  bit cmp_en = 0;

  always #2 clk = ~clk;

  phy_mgmt_ctrl #(.TIMEOUT_CYC(T)) i_phy_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .loopback_o(loopback_o), .isolate_o(isolate_o), .pwrdn_o(pwrdn_o),
    .full_dplx_o(full_dplx_o), .col_test_o(col_test_o),
    .col_det_en_o(col_det_en_o), .srst_pulse_o(srst_pulse_o),
    .err_clear_o(err_clear_o), .busy_o(busy_o)
  );

  // behavioural reference model
  bit m_s1, m_s2;
  bit m_lb, m_pd, m_iso, m_dup, m_ct, m_pulse, m_ec;
  int m_rst_left, m_pu_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !m_s2) begin
      if (!rst_n) begin m_s1 <= 0; m_s2 <= 0; end
      else begin m_s1 <= 1; m_s2 <= m_s1; end
      m_lb <= 0; m_pd <= 0; m_iso <= (phy_addr == 0); m_dup <= 0; m_ct <= 0;
      m_pulse <= 0; m_ec <= 0; m_rst_left <= 0; m_pu_left <= 0;
    end else begin
      int nr, np;
      bit ec, acc;
      nr = m_rst_left; np = m_pu_left; ec = 0;
      if (nr > 0) nr--;
      if (np > 0) begin np--; if (np == 0) ec = 1; end
      acc = reg_wr && reg_addr == 0 && m_rst_left == 0;
      m_pulse <= 0;
      if (acc && reg_wdata[15]) begin
        m_lb <= 0; m_pd <= 0; m_iso <= (phy_addr == 0); m_dup <= 0; m_ct <= 0;
        nr = T; np = 0; ec = 0; m_pulse <= 1;
      end else if (acc) begin
        if (reg_wdata[11]) begin np = 0; ec = 0; end
        else if (m_pd) begin np = T; ec = 0; end
        m_lb <= reg_wdata[14]; m_pd <= reg_wdata[11]; m_iso <= reg_wdata[10];
        m_dup <= reg_wdata[8]; m_ct <= reg_wdata[7];
      end
      m_rst_left <= nr; m_pu_left <= np; m_ec <= ec;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_word();
    logic [15:0] w;
    w = 16'h2000;
    w[15] = (m_rst_left > 0);
    w[14] = m_lb; w[11] = m_pd; w[10] = m_iso; w[8] = m_dup; w[7] = m_ct;
    return (reg_addr == 0) ? w : 16'h0;
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      bit mb;
      mb = (m_rst_left > 0) || (m_pu_left > 0);
      chk("R2/R3 rdata", reg_rdata, model_word());
      chk("R4 busy", busy_o, mb);
      chk("R6 srst_pulse", srst_pulse_o, m_pulse);
      chk("R9 err_clear", err_clear_o, m_ec);
      chk("R7 loopback", loopback_o, m_lb);
      chk("R8 isolate", isolate_o, m_iso | m_pd | mb);
      chk("R8 pwrdn", pwrdn_o, m_pd | (m_pu_left > 0));
      chk("R12 full_dplx", full_dplx_o, m_dup);
      chk("R12 col_test", col_test_o, m_ct);
      chk("R7 col_det_en", col_det_en_o, !m_lb | m_ct);
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic do_reset(input logic [4:0] pa);
    cmp_en = 0;
    @(posedge clk); #1;
    rst_n = 0; phy_addr = pa;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1 cmp_en = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    do_reset(5'd0);
    @(negedge clk);
    chk("R1 reset word addr0", reg_rdata, 16'h2400);
    chk("R1 isolate", isolate_o, 1);
    chk("R1 busy", busy_o, 0);
    chk("R1 pulse", srst_pulse_o | err_clear_o, 0);

    // R2 R3 R8: all writable bits except reset, plus fixed-bit noise
    wr_reg(5'd0, 16'h7FFF);
    @(negedge clk);
    chk("R2 R3 stored word", reg_rdata, 16'h6D80);
    chk("R8 pwrdn_o", pwrdn_o, 1);
    chk("R8 isolate_o", isolate_o, 1);

    // R9: leave power-down
    wr_reg(5'd0, 16'h4180);
    @(negedge clk);
    n = 0;
    while (busy_o && n < 100) begin
      chk("R9 pwrdn held", pwrdn_o, 1);
      chk("R9 isolate held", isolate_o, 1);
      n++;
      @(negedge clk);
    end
    chk("R9 power-up length", n, T);
    chk("R9 err_clear after", err_clear_o, 1);
    chk("R9 rdata after", reg_rdata, 16'h6180);
    chk("R7 col_det with coltest", col_det_en_o, 1);
    chk("R12 full_dplx", full_dplx_o, 1);
    @(negedge clk);
    chk("R9 err_clear single", err_clear_o, 0);

    wr_reg(5'd0, 16'h4000);
    @(negedge clk);
    chk("R7 loopback_o", loopback_o, 1);
    chk("R7 col_det off", col_det_en_o, 0);

    // R10 other address
    wr_reg(5'd1, 16'h0100);
    @(negedge clk);
    chk("R10 write ignored", reg_rdata, 16'h6000);
    reg_addr = 5'd1;
    @(negedge clk);
    chk("R10 read other addr", reg_rdata, 16'h0000);
    @(posedge clk); #1 reg_addr = 5'd0;

    // R4 R6 R5 soft reset
    wr_reg(5'd0, 16'hC100);
    @(negedge clk);
    chk("R6 pulse high", srst_pulse_o, 1);
    chk("R4 defaults bit15", reg_rdata, 16'hA400);
    @(negedge clk);
    chk("R6 pulse low", srst_pulse_o, 0);
    wr_reg(5'd0, 16'h0100);
    @(negedge clk);
    chk("R5 write blocked", reg_rdata, 16'hA400);
    n = 0;
    while (reg_rdata[15] && n < 100) begin n++; @(negedge clk); end
    chk("R4 cleared word", reg_rdata, 16'h2400);

    // R11 soft reset during power-up, exact reset length
    wr_reg(5'd0, 16'h0800);
    wr_reg(5'd0, 16'h0000);
    repeat (2) @(posedge clk);
    wr_reg(5'd0, 16'h8000);
    @(negedge clk);
    n = 0; seen = 0;
    while (reg_rdata[15] && n < 100) begin
      if (err_clear_o) seen = 1;
      n++; @(negedge clk);
    end
    chk("R4 R11 reset length", n, T);
    chk("R11 no err_clear", seen | err_clear_o, 0);

    // R11 power-down set again during power-up
    wr_reg(5'd0, 16'h0800);
    wr_reg(5'd0, 16'h0000);
    repeat (2) @(posedge clk);
    wr_reg(5'd0, 16'h0800);
    @(negedge clk);
    chk("R11 cancel busy", busy_o, 0);
    seen = 0;
    repeat (T + 2) begin
      if (err_clear_o) seen = 1;
      @(negedge clk);
    end
    chk("R11 cancel no err_clear", seen, 0);

    do_reset(5'd3);
    @(negedge clk);
    chk("R1 reset word addr3", reg_rdata, 16'h2000);
    chk("R1 isolate addr3", isolate_o, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule